// File: doc/BRIEF.md
# Bit-Control Port with Pattern Interrupt

An 8-bit parallel port that a processor programs through a small write-only register file and reads through a single read bus. A 2-bit mode setting makes all pins outputs, all inputs, or bidirectional (only inputs are sampled here, since byte handshaking lies outside this block), or puts the port in bit control mode, where each pin's direction is chosen on its own. Input pins pass through a two-flop synchronizer. The read bus returns the synchronized pin value for input pins and the output data value for output pins.

In bit control mode a pattern detector watches the pins that are not masked. Software picks the active level (high or low). It also picks whether any one watched pin or all watched pins must be at that level. When the condition changes from false to true, a single interrupt-request level is raised toward an external priority chain. The request stays high until it is acknowledged. A condition that simply remains true does not raise it again.

Top module: `bitport_irq`

## Requirements
- R1: After reset, mode is byte input (01), output data is 0x00, select is 0xFF, mask is 0xFF, control is 00, `pin_oe` is 0x00 and `irq` is low.
- R2: A write to address 0 loads output data, which appears on `pin_out` after the write edge. In mode 00 (byte output) `pin_oe` is 0xFF.
- R3: In mode 01 (byte input) and in mode 10 (bidirectional), `pin_oe` is 0x00.
- R4: In mode 11 (bit control), select (address 2) sets each pin's direction. A select bit of 1 makes that pin an input, so `pin_oe` is the inverse of select.
- R5: `rd_data` shows the output data bit for output pins. For input pins it shows the pin value delayed by two clock edges, and one edge after a pin change the old value is still shown.
- R6: With control (address 4) bit1=0 (any) and bit0=1 (active high), the condition is true when at least one unmasked pin reads high. Mask (address 3) bit 1 means the pin is ignored.
- R7: With control bit1=1 (all), the condition is true only when every unmasked pin reads the active level. Control bit0=0 selects active low.
- R8: `irq` rises one edge after the condition turns true and is cleared by `irq_ack`. A condition that stays true does not raise it again, but a later false-to-true change does.
- R9: When all eight mask bits are 1, no interrupt is raised.
- R10: Outside mode 11 the condition is false and `irq` is never raised, whatever the mask and control values are.
- R11: If a new false-to-true change and `irq_ack` fall in the same cycle, `irq` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 data, 1 mode, 2 select, 3 mask, 4 control |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Input register read value |
| pin_in | input | 8 | Pin input levels |
| pin_out | output | 8 | Pin output levels |
| pin_oe | output | 8 | Per-pin output enable |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Interrupt request level |

## Verification
Raising a new request and clearing the old one can happen in the same cycle. The bench creates this case by holding `irq` high and making the watched pins false. It then drives them true and asserts `irq_ack` exactly in the cycle before the synchronized change reaches the interrupt register. The expected result is that `irq` stays high, because the new event takes priority over the acknowledge. A plain acknowledge with no new event must clear `irq`, and both cases are checked.

// File: rtl/bitport_irq.sv
module bitport_irq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  input  logic         irq_ack,
  output logic         irq
);
  localparam logic [1:0] M_OUT = 2'b00, M_IN = 2'b01, M_BIDI = 2'b10, M_BIT = 2'b11;

  logic [1:0]   mode;
  logic [1:0]   ctl;
  logic [W-1:0] dout, sel, mask, sync1, sync2;
  logic         hit, hit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= M_IN;
      dout <= '0;
      sel  <= '1;
      mask <= '1;
      ctl  <= 2'b00;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: dout <= wr_data;
        3'd1: mode <= wr_data[1:0];
        3'd2: sel  <= wr_data;
        3'd3: mask <= wr_data;
        3'd4: ctl  <= wr_data[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
    end
  end

  always_comb begin
    case (mode)
      M_OUT:   pin_oe = '1;
      M_BIT:   pin_oe = ~sel;
      default: pin_oe = '0;
    endcase
  end

  assign pin_out = dout;
  assign rd_data = (pin_oe & dout) | (~pin_oe & sync2);

  logic [W-1:0] watch, lvl;
  assign watch = ~mask;
  assign lvl   = ctl[0] ? rd_data : ~rd_data;
  assign hit   = (mode == M_BIT) && (watch != '0) &&
                 (ctl[1] ? ((lvl & watch) == watch) : ((lvl & watch) != '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      irq   <= 1'b0;
    end else begin
      hit_q <= hit;
      if (hit && !hit_q) irq <= 1'b1;
      else if (irq_ack)  irq <= 1'b0;
    end
  end
endmodule

module bitport_irq_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         irq,
  input logic         irq_ack,
  input logic         hit,
  input logic         hit_q,
  input logic [1:0]   mode,
  input logic [W-1:0] mask
);
  a_r11_event_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !hit_q) |=> irq);
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !(hit && !hit_q)) |=> !irq);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !(hit && !hit_q)) |=> !irq);
  a_r10_quiet_outside_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b11) |-> !hit);
  a_r9_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '1) |-> !hit);
endmodule

bind bitport_irq bitport_irq_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .irq_ack(irq_ack),
  .hit(hit), .hit_q(hit_q), .mode(mode), .mask(mask)
);

// File: tb/test_bitport_irq.sv
module test_bitport_irq;
  logic       clk = 0, rst_n = 0, wr_en = 0, irq_ack = 0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0, pin_in = '0;
  logic [7:0] rd_data, pin_out, pin_oe;
  logic       irq;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  bitport_irq i_bitport_irq (.*);

  // {mask, ctl, pins, expected irq}
  localparam logic [18:0] VEC [9] = '{
    {8'hF0, 2'b01, 8'h01, 1'b1},
    {8'hF0, 2'b01, 8'hF0, 1'b0},
    {8'hF0, 2'b11, 8'h0F, 1'b1},
    {8'hF0, 2'b11, 8'h0E, 1'b0},
    {8'h00, 2'b10, 8'h00, 1'b1},
    {8'h00, 2'b10, 8'h80, 1'b0},
    {8'h0F, 2'b00, 8'h0F, 1'b1},
    {8'h0F, 2'b00, 8'hFF, 1'b0},
    {8'hFF, 2'b00, 8'h00, 1'b0}
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic ack();
    irq_ack = 1; cyc(1); irq_ack = 0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cyc(2); rst_n = 1; @(negedge clk);
    chk("R1 oe", pin_oe, 8'h00);
    chk("R1 out", pin_out, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    wr(3'd1, 8'h03);
    chk("R1 select reset FF", pin_oe, 8'h00);
    wr(3'd1, 8'h01);

    wr(3'd0, 8'h5A);
    chk("R2 data", pin_out, 8'h5A);
    wr(3'd1, 8'h00);
    chk("R2 oe", pin_oe, 8'hFF);
    wr(3'd1, 8'h02);
    chk("R3 bidi oe", pin_oe, 8'h00);
    wr(3'd1, 8'h01);
    chk("R3 in oe", pin_oe, 8'h00);

    wr(3'd1, 8'h03);
    wr(3'd2, 8'h0F);
    chk("R4 oe", pin_oe, 8'hF0);
    wr(3'd0, 8'hA5);
    pin_in = 8'h00; cyc(3);
    pin_in = 8'h3C; cyc(1);
    chk("R5 one edge", rd_data, 8'hA0);
    cyc(1);
    chk("R5 two edges", rd_data, 8'hAC);

    wr(3'd2, 8'hFF);
    foreach (VEC[i]) begin
      wr(3'd3, 8'hFF);
      cyc(1); ack();
      pin_in = VEC[i][8:1]; cyc(3);
      wr(3'd4, {6'b0, VEC[i][10:9]});
      wr(3'd3, VEC[i][18:11]);
      cyc(2);
      chk(VEC[i][18:11] == 8'hFF ? "R9 vec" : (VEC[i][10] ? "R7 vec" : "R6 vec"),
          {7'b0, irq}, {7'b0, VEC[i][0]});
    end

    wr(3'd3, 8'hFF); cyc(1); ack();
    wr(3'd4, 8'h01); pin_in = 8'h01; cyc(3);
    wr(3'd3, 8'hFE); cyc(1);
    chk("R8 raise", {7'b0, irq}, 8'h01);
    ack();
    chk("R8 ack clears", {7'b0, irq}, 8'h00);
    cyc(5);
    chk("R8 held no retrigger", {7'b0, irq}, 8'h00);
    pin_in = 8'h00; cyc(4);
    pin_in = 8'h01; cyc(3);
    chk("R8 new edge", {7'b0, irq}, 8'h01);

    pin_in = 8'h00; cyc(4);
    chk("R11 pre", {7'b0, irq}, 8'h01);
    pin_in = 8'h01; cyc(2);
    irq_ack = 1; cyc(1); irq_ack = 0;
    chk("R11 event wins", {7'b0, irq}, 8'h01);
    ack();

    wr(3'd1, 8'h01); wr(3'd3, 8'h00); wr(3'd4, 8'h01);
    pin_in = 8'h00; cyc(3); pin_in = 8'hFF; cyc(5);
    chk("R10 input mode", {7'b0, irq}, 8'h00);
    wr(3'd1, 8'h02); pin_in = 8'h00; cyc(3); pin_in = 8'hFF; cyc(5);
    chk("R10 bidi mode", {7'b0, irq}, 8'h00);
    chk("R10 rd input", rd_data, 8'hFF);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule